// File: doc/BRIEF.md
# Two-Byte Accumulator CPU Sequencer

This block is the control core of a small 8-bit accumulator processor with a 256-byte address space. It holds the accumulator, the instruction pointer and a four-bit flag set. Four sense-switch inputs sit alongside the flags as the upper half of an 8-bit status byte. The core runs a multicycle fetch, decode and execute loop over one shared memory port that has separate read and write strobes. Every instruction takes two bytes: an opcode byte, then an operand byte. The opcode's high nibble picks the instruction group and the addressing mode, and its low nibble picks the operation.

Out of reset the core reads its start address from the top memory location and begins fetching there. Loads, stores, add, subtract, jumps, flag tests and flag toggles take either the operand byte itself or the byte that the operand points to. Accumulator shifts and rotates are handled by a separate combinational ALU. A wait input lets an external agent hold the machine between instructions. A halt instruction parks the core until the next reset. Opcodes outside the supported set behave as two-byte no-ops.

Top module: `acc8_sequencer`

## Requirements
- R1: While reset is held, both strobes and both bus enables are high. After `rst_n` is released, the first bus cycle reads address 0xFF. The byte read there becomes IP, and the next read is at that address.
- R2: Each instruction reads its opcode at IP and its operand at IP+1. Only after that does it make an indirect read, if it has one. Instructions that do not jump and do not halt advance IP by 2.
- R3: An opcode with high nibble 0x5 uses the operand byte as its value. High nibble 0x6 uses the byte read from the address held in the operand. The low nibble selects 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 jump-if-zero, 6 flag-skip, 7 flag-toggle.
- R4: Store with high nibble 0x5 writes A to the operand address. With high nibble 0x6 it writes A to the address read from the operand location. The write cycle has `wr_n` and `data_oe_n` low, and a store changes neither A nor the flags.
- R5: The status byte is {sense_sw[3:0], O, N, Z, C}, with O at bit 3, N at bit 2, Z at bit 1 and C at bit 0. Add sets C to the carry out. Subtract sets C when a borrow occurs. Both set O on signed overflow, and Z and N from the result.
- R6: Load sets Z and N from the loaded value and leaves C and O unchanged.
- R7: Jump (low nibble 4) loads IP with the value. Jump-if-zero (low nibble 5) does the same only when Z is 1, and otherwise advances IP by 2.
- R8: Flag-skip (low nibble 6) advances IP by 4 when any status bit selected by the value mask is 1, and by 2 otherwise. Flag-toggle (low nibble 7) inverts the flags selected by mask bits 3..0.
- R9: Opcodes 0xF0, 0xF1, 0xF2 and 0xF3 rotate A left, rotate A right, shift A left with a zero fill, and shift A right keeping bit 7. C receives the bit shifted out, Z and N follow the result, and O is kept.
- R10: Opcode 0x01 halts the core. After its operand fetch, no further read or write cycle occurs until reset.
- R11: Opcode 0x00 and every unassigned opcode (any other high nibble, low nibble 8..F in groups 0x5 and 0x6, 0xF4..0xFF) only advance IP by 2. They make no indirect read and no write, and change neither A nor the flags.
- R12: If `wait_n` is low in the last cycle of an instruction, that instruction completes, including its write. After that, no bus cycle starts until `wait_n` returns high.
- R13: `addr_oe_n` is low exactly when a read or write strobe is low. `data_oe_n` is low only during write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wait_n | input | 1 | Low requests a pause at the next instruction boundary |
| sense_sw | input | 4 | Sense switches, visible as status bits 7..4 |
| mem_rdata | input | 8 | Read data returned by memory in the same cycle |
| mem_addr | output | 8 | Memory address, zero when idle |
| mem_wdata | output | 8 | Write data (accumulator) during write cycles |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| addr_oe_n | output | 1 | Low while the core drives the address bus |
| data_oe_n | output | 1 | Low while the core drives the data bus |

## Verification
The bench runs short machine-code programs that differ in which outcome they separate. One mixes immediate and indirect operands, and its logged read addresses tell the two modes apart and show operand ordering. Another uses add and subtract values chosen so that carry, borrow and signed overflow each appear both alone and absent. Every flag is then probed with flag-skip instructions that guard marker stores, so a wrong flag shows up as a missing or extra memory write. Further programs take jump-if-zero both ways and run the shift group, the no-op groups, a halt, and a wait asserted during a store. Together these expose extra bus cycles, lost writes and fetches made while paused.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_OPC,
    ST_ARG,
    ST_IND,
    ST_EXE,
    ST_PAUSE,
    ST_HALT
  } state_t;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_HLT,
    OP_LDA,
    OP_STO,
    OP_ADD,
    OP_SUB,
    OP_JMP,
    OP_JEQ,
    OP_JFL,
    OP_FTG,
    OP_RSL,
    OP_RSR,
    OP_ASL,
    OP_ASR
  } op_t;

  localparam logic [3:0] GRP_SYS = 4'h0;
  localparam logic [3:0] GRP_IMM = 4'h5;
  localparam logic [3:0] GRP_IND = 4'h6;
  localparam logic [3:0] GRP_SHF = 4'hF;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_O = 3;
  localparam int FLG_W = 4;

endpackage

// File: rtl/acc8_rst_sync.sv
module acc8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output op_t           op,
  output logic          indirect
);

  logic [3:0] grp;
  logic [3:0] fn;

  assign grp = opcode[DW-1 -: 4];
  assign fn  = opcode[3:0];

  always_comb begin
    op       = OP_NOP;
    indirect = 1'b0;
    case (grp)
      GRP_SYS: begin
        if (fn == 4'h1) op = OP_HLT;
      end
      GRP_IMM, GRP_IND: begin
        case (fn)
          4'h0:    op = OP_LDA;
          4'h1:    op = OP_STO;
          4'h2:    op = OP_ADD;
          4'h3:    op = OP_SUB;
          4'h4:    op = OP_JMP;
          4'h5:    op = OP_JEQ;
          4'h6:    op = OP_JFL;
          4'h7:    op = OP_FTG;
          default: op = OP_NOP;
        endcase
        indirect = (grp == GRP_IND) && !fn[3];
      end
      GRP_SHF: begin
        case (fn)
          4'h0:    op = OP_RSL;
          4'h1:    op = OP_RSR;
          4'h2:    op = OP_ASL;
          4'h3:    op = OP_ASR;
          default: op = OP_NOP;
        endcase
      end
      default: op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_t              op,
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    val,
  input  logic [FLG_W-1:0] flg_in,
  output logic [DW-1:0]    res,
  output logic [FLG_W-1:0] flg_out,
  output logic             acc_we
);

  localparam int MSB = DW - 1;

  logic [DW:0] sum_w;
  logic [DW:0] dif_w;

  assign sum_w = {1'b0, acc} + {1'b0, val};
  assign dif_w = {1'b0, acc} - {1'b0, val};

  always_comb begin
    res     = acc;
    flg_out = flg_in;
    acc_we  = 1'b0;
    case (op)
      OP_LDA: begin
        res    = val;
        acc_we = 1'b1;
      end
      OP_ADD: begin
        res            = sum_w[DW-1:0];
        flg_out[FLG_C] = sum_w[DW];
        flg_out[FLG_O] = (acc[MSB] == val[MSB]) && (sum_w[MSB] != acc[MSB]);
        acc_we         = 1'b1;
      end
      OP_SUB: begin
        res            = dif_w[DW-1:0];
        flg_out[FLG_C] = dif_w[DW];
        flg_out[FLG_O] = (acc[MSB] != val[MSB]) && (dif_w[MSB] != acc[MSB]);
        acc_we         = 1'b1;
      end
      OP_RSL: begin
        res            = {acc[DW-2:0], acc[MSB]};
        flg_out[FLG_C] = acc[MSB];
        acc_we         = 1'b1;
      end
      OP_RSR: begin
        res            = {acc[0], acc[DW-1:1]};
        flg_out[FLG_C] = acc[0];
        acc_we         = 1'b1;
      end
      OP_ASL: begin
        res            = {acc[DW-2:0], 1'b0};
        flg_out[FLG_C] = acc[MSB];
        acc_we         = 1'b1;
      end
      OP_ASR: begin
        res            = {acc[MSB], acc[DW-1:1]};
        flg_out[FLG_C] = acc[0];
        acc_we         = 1'b1;
      end
      OP_FTG: begin
        flg_out = flg_in ^ val[FLG_W-1:0];
      end
      default: begin
        res = acc;
      end
    endcase
    if (acc_we) begin
      flg_out[FLG_Z] = (res == '0);
      flg_out[FLG_N] = res[MSB];
    end
  end

endmodule

// File: rtl/acc8_sequencer.sv
module acc8_sequencer
  import acc8_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SW_W     = 4,
  parameter int RST_SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wait_n,
  input  logic [SW_W-1:0] sense_sw,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            rd_n,
  output logic            wr_n,
  output logic            addr_oe_n,
  output logic            data_oe_n
);

  localparam int             ST_W     = SW_W + FLG_W;
  localparam logic [DW-1:0]  BOOT_VEC = '1;
  localparam logic [DW-1:0]  INC1     = DW'(1);
  localparam logic [DW-1:0]  INC2     = DW'(2);
  localparam logic [DW-1:0]  INC4     = DW'(4);

  logic core_rst_n;

  state_t           state_q, state_d;
  logic [DW-1:0]    ip_q, ip_d;
  logic [DW-1:0]    acc_q;
  logic [FLG_W-1:0] flg_q;
  logic [DW-1:0]    ir_q, ir_d;
  logic [DW-1:0]    opr_q, opr_d;
  logic             ip_en, ir_en, opr_en, acc_en, flg_en;

  op_t              dec_op;
  logic             dec_ind;
  logic [DW-1:0]    alu_res;
  logic [FLG_W-1:0] alu_flg;
  logic             alu_we;

  logic             rd_act, wr_act;
  logic [DW-1:0]    addr_d;
  logic [ST_W-1:0]  status_w;
  logic             flag_hit;

  acc8_rst_sync #(.STAGES(RST_SYNC)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  acc8_decode #(.DW(DW)) u_dec (
    .opcode   (ir_q),
    .op       (dec_op),
    .indirect (dec_ind)
  );

  acc8_alu #(.DW(DW)) u_alu (
    .op      (dec_op),
    .acc     (acc_q),
    .val     (opr_q),
    .flg_in  (flg_q),
    .res     (alu_res),
    .flg_out (alu_flg),
    .acc_we  (alu_we)
  );

  assign status_w = {sense_sw, flg_q};
  assign flag_hit = |(status_w & opr_q[ST_W-1:0]);

  // next-state and bus control
  always_comb begin
    state_d = state_q;
    ip_d    = ip_q;
    ir_d    = ir_q;
    opr_d   = opr_q;
    ip_en   = 1'b0;
    ir_en   = 1'b0;
    opr_en  = 1'b0;
    acc_en  = 1'b0;
    flg_en  = 1'b0;
    rd_act  = 1'b0;
    wr_act  = 1'b0;
    addr_d  = '0;
    if (core_rst_n) begin
      case (state_q)
        ST_BOOT: begin
          rd_act  = 1'b1;
          addr_d  = BOOT_VEC;
          ip_d    = mem_rdata;
          ip_en   = 1'b1;
          state_d = ST_OPC;
        end
        ST_OPC: begin
          rd_act  = 1'b1;
          addr_d  = ip_q;
          ir_d    = mem_rdata;
          ir_en   = 1'b1;
          state_d = ST_ARG;
        end
        ST_ARG: begin
          rd_act  = 1'b1;
          addr_d  = ip_q + INC1;
          opr_d   = mem_rdata;
          opr_en  = 1'b1;
          state_d = dec_ind ? ST_IND : ST_EXE;
        end
        ST_IND: begin
          rd_act  = 1'b1;
          addr_d  = opr_q;
          opr_d   = mem_rdata;
          opr_en  = 1'b1;
          state_d = ST_EXE;
        end
        ST_EXE: begin
          ip_en  = 1'b1;
          acc_en = alu_we;
          flg_en = 1'b1;
          case (dec_op)
            OP_STO: begin
              wr_act = 1'b1;
              addr_d = opr_q;
              ip_d   = ip_q + INC2;
            end
            OP_JMP:  ip_d = opr_q;
            OP_JEQ:  ip_d = flg_q[FLG_Z] ? opr_q : ip_q + INC2;
            OP_JFL:  ip_d = flag_hit ? ip_q + INC4 : ip_q + INC2;
            OP_HLT:  ip_en = 1'b0;
            default: ip_d = ip_q + INC2;
          endcase
          if (dec_op == OP_HLT) begin
            state_d = ST_HALT;
          end else if (!wait_n) begin
            state_d = ST_PAUSE;
          end else begin
            state_d = ST_OPC;
          end
        end
        ST_PAUSE: begin
          if (wait_n) state_d = ST_OPC;
        end
        ST_HALT: begin
          state_d = ST_HALT;
        end
        default: begin
          state_d = ST_HALT;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_BOOT;
      ip_q    <= '0;
      ir_q    <= '0;
      opr_q   <= '0;
      acc_q   <= '0;
      flg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ip_en)  ip_q  <= ip_d;
      if (ir_en)  ir_q  <= ir_d;
      if (opr_en) opr_q <= opr_d;
      if (acc_en) acc_q <= alu_res;
      if (flg_en) flg_q <= alu_flg;
    end
  end

  assign mem_addr  = addr_d;
  assign mem_wdata = wr_act ? acc_q : '0;
  assign rd_n      = ~rd_act;
  assign wr_n      = ~wr_act;
  assign addr_oe_n = ~(rd_act | wr_act);
  assign data_oe_n = ~wr_act;

  // R1
  boot_vec_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == ST_BOOT) |=> (ip_q == $past(mem_rdata)));

  // R2
  ip_step_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == ST_EXE && dec_op != OP_JMP && dec_op != OP_JEQ &&
     dec_op != OP_JFL && dec_op != OP_HLT) |=> (ip_q == $past(ip_q) + INC2));

  // R7
  jmp_tgt_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == ST_EXE && dec_op == OP_JMP) |=> (ip_q == $past(opr_q)));

  // R4
  sto_keep_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == ST_EXE && dec_op == OP_STO) |=> ($stable(acc_q) && $stable(flg_q)));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == ST_HALT) |=> (state_q == ST_HALT && $stable(ip_q) && rd_n && wr_n));

  // R12
  wait_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == ST_EXE && !wait_n && dec_op != OP_HLT) |=> (rd_n && wr_n));

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(!rd_n && !wr_n));

endmodule

// File: tb/sim_acc8_sequencer.sv
`timescale 1ns/100ps
module sim_acc8_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wait_n = 1'b1;
  logic [3:0] sense_sw = 4'b0000;
  logic [7:0] mem_rdata, mem_addr, mem_wdata;
  logic       rd_n, wr_n, addr_oe_n, data_oe_n;

  logic [7:0] mem [0:255];
  logic       ld_clr = 1'b0;
  logic       ld_en  = 1'b0;
  logic [7:0] ld_a   = 8'h00;
  logic [7:0] ld_d   = 8'h00;

  logic [7:0] rlog [0:63];
  int         rcnt, wcnt;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  acc8_sequencer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_n    (wait_n),
    .sense_sw  (sense_sw),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr_oe_n (addr_oe_n),
    .data_oe_n (data_oe_n)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hEE;
    end else if (ld_en) begin
      mem[ld_a] <= ld_d;
    end else if (wr_n === 1'b0) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      rcnt = 0;
      wcnt = 0;
    end else begin
      if (rd_n === 1'b0) begin
        if (rcnt < 64) rlog[rcnt] = mem_addr;
        rcnt = rcnt + 1;
      end
      if (wr_n === 1'b0) wcnt = wcnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic start_prog();
    @(negedge clk);
    rst_n  = 1'b0;
    wait_n = 1'b1;
    ld_clr = 1'b1;
    @(negedge clk);
    ld_clr = 1'b0;
    poke(8'hFF, 8'h10);
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] op, input logic [7:0] arg);
    poke(a, op);
    poke(a + 8'd1, arg);
  endtask

  task automatic run(input int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    start_prog();
    put(8'h10, 8'h01, 8'h00);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "rd_n in reset", rd_n, 1);
    chk("R1", "wr_n in reset", wr_n, 1);
    chk("R13", "addr_oe_n in reset", addr_oe_n, 1);
    chk("R13", "data_oe_n in reset", data_oe_n, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #1;
      if (!rd_n) break;
    end
    chk("R1", "first read address", mem_addr, 8'hFF);
    chk("R13", "addr_oe_n on read", addr_oe_n, 0);
    chk("R13", "data_oe_n on read", data_oe_n, 1);
    @(negedge clk);
    #1;
    chk("R1", "fetch from vector", mem_addr, 8'h10);
  endtask

  task automatic t_modes();
    logic [7:0] exp_rd [0:12];
    exp_rd = '{8'hFF, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'hA0,
               8'h16, 8'h17, 8'hA1, 8'h18, 8'h19};
    start_prog();
    put(8'h10, 8'h50, 8'h3C);
    put(8'h12, 8'h51, 8'h80);
    put(8'h14, 8'h60, 8'hA0);
    put(8'h16, 8'h61, 8'hA1);
    put(8'h18, 8'h01, 8'h00);
    poke(8'hA0, 8'h5A);
    poke(8'hA1, 8'h82);
    run(80);
    chk("R4", "immediate store", mem[8'h80], 8'h3C);
    chk("R3", "indirect load via store", mem[8'h82], 8'h5A);
    chk("R4", "indirect pointer untouched", mem[8'hA1], 8'h82);
    chk("R2", "read count", rcnt, 13);
    chk("R4", "write count", wcnt, 2);
    for (int i = 0; i < 13; i++) chk("R2", $sformatf("read %0d address", i), rlog[i], exp_rd[i]);
  endtask

  task automatic t_arith();
    start_prog();
    put(8'h10, 8'h50, 8'h7F);
    put(8'h12, 8'h52, 8'h01);
    put(8'h14, 8'h51, 8'h80);
    put(8'h16, 8'h56, 8'h08);
    put(8'h18, 8'h51, 8'h81);
    put(8'h1A, 8'h56, 8'h01);
    put(8'h1C, 8'h51, 8'h82);
    put(8'h1E, 8'h50, 8'h00);
    put(8'h20, 8'h56, 8'h08);
    put(8'h22, 8'h51, 8'h88);
    put(8'h24, 8'h53, 8'h01);
    put(8'h26, 8'h51, 8'h83);
    put(8'h28, 8'h56, 8'h01);
    put(8'h2A, 8'h51, 8'h84);
    put(8'h2C, 8'h56, 8'h08);
    put(8'h2E, 8'h51, 8'h85);
    put(8'h30, 8'h50, 8'h80);
    put(8'h32, 8'h53, 8'h01);
    put(8'h34, 8'h56, 8'h08);
    put(8'h36, 8'h51, 8'h86);
    put(8'h38, 8'h56, 8'h02);
    put(8'h3A, 8'h51, 8'h87);
    put(8'h3C, 8'h01, 8'h00);
    run(150);
    chk("R5", "7F+01 result", mem[8'h80], 8'h80);
    chk("R5", "overflow after 7F+01 skips", mem[8'h81], 8'hEE);
    chk("R5", "no carry after 7F+01", mem[8'h82], 8'h80);
    chk("R6", "load keeps overflow", mem[8'h88], 8'hEE);
    chk("R5", "00-01 result", mem[8'h83], 8'hFF);
    chk("R5", "borrow after 00-01 skips", mem[8'h84], 8'hEE);
    chk("R5", "no overflow after 00-01", mem[8'h85], 8'hFF);
    chk("R5", "overflow after 80-01 skips", mem[8'h86], 8'hEE);
    chk("R8", "zero clear mask 02 falls through", mem[8'h87], 8'h7F);
  endtask

  task automatic t_jumps();
    start_prog();
    put(8'h10, 8'h50, 8'h05);
    put(8'h12, 8'h53, 8'h05);
    put(8'h14, 8'h55, 8'h30);
    put(8'h16, 8'h51, 8'h85);
    put(8'h18, 8'h01, 8'h00);
    put(8'h30, 8'h50, 8'h11);
    put(8'h32, 8'h51, 8'h86);
    put(8'h34, 8'h64, 8'hA2);
    put(8'h36, 8'h50, 8'h22);
    put(8'h38, 8'h51, 8'h87);
    put(8'h3A, 8'h01, 8'h00);
    put(8'h40, 8'h52, 8'h01);
    put(8'h42, 8'h55, 8'h50);
    put(8'h44, 8'h51, 8'h88);
    put(8'h46, 8'h01, 8'h00);
    put(8'h50, 8'h01, 8'h00);
    poke(8'hA2, 8'h40);
    run(100);
    chk("R7", "taken jump-if-zero skips store", mem[8'h85], 8'hEE);
    chk("R7", "code at jump target ran", mem[8'h86], 8'h11);
    chk("R7", "indirect jump skips store", mem[8'h87], 8'hEE);
    chk("R7", "untaken jump-if-zero falls through", mem[8'h88], 8'h12);
  endtask

  task automatic t_shifts();
    start_prog();
    sense_sw = 4'b1000;
    put(8'h10, 8'h50, 8'h81);
    put(8'h12, 8'hF0, 8'h00);
    put(8'h14, 8'h51, 8'h80);
    put(8'h16, 8'hF1, 8'h00);
    put(8'h18, 8'h51, 8'h81);
    put(8'h1A, 8'hF2, 8'h00);
    put(8'h1C, 8'h51, 8'h82);
    put(8'h1E, 8'h50, 8'h82);
    put(8'h20, 8'hF3, 8'h00);
    put(8'h22, 8'h51, 8'h83);
    put(8'h24, 8'h57, 8'h01);
    put(8'h26, 8'h56, 8'h01);
    put(8'h28, 8'h51, 8'h84);
    put(8'h2A, 8'h56, 8'h80);
    put(8'h2C, 8'h51, 8'h85);
    put(8'h2E, 8'h56, 8'h40);
    put(8'h30, 8'h51, 8'h86);
    put(8'h32, 8'h57, 8'h01);
    put(8'h34, 8'h56, 8'h01);
    put(8'h36, 8'h51, 8'h87);
    put(8'h38, 8'h01, 8'h00);
    run(120);
    sense_sw = 4'b0000;
    chk("R9", "rotate left 81", mem[8'h80], 8'h03);
    chk("R9", "rotate right 03", mem[8'h81], 8'h81);
    chk("R9", "shift left 81", mem[8'h82], 8'h02);
    chk("R9", "shift right 82 keeps sign", mem[8'h83], 8'hC1);
    chk("R8", "toggle sets carry, skip taken", mem[8'h84], 8'hEE);
    chk("R8", "sense switch bit 7 skip", mem[8'h85], 8'hEE);
    chk("R8", "clear sense bit 6 no skip", mem[8'h86], 8'hC1);
    chk("R8", "second toggle clears carry", mem[8'h87], 8'hC1);
  endtask

  task automatic t_nops();
    start_prog();
    put(8'h10, 8'h50, 8'h44);
    put(8'h12, 8'h00, 8'h00);
    put(8'h14, 8'h58, 8'h99);
    put(8'h16, 8'h90, 8'h12);
    put(8'h18, 8'hF7, 8'h00);
    put(8'h1A, 8'h6A, 8'h80);
    put(8'h1C, 8'h02, 8'h00);
    put(8'h1E, 8'h51, 8'h80);
    put(8'h20, 8'h56, 8'h0F);
    put(8'h22, 8'h51, 8'h81);
    put(8'h24, 8'h01, 8'h00);
    run(120);
    chk("R11", "A kept across no-ops", mem[8'h80], 8'h44);
    chk("R11", "flags kept across no-ops", mem[8'h81], 8'h44);
    chk("R11", "no extra writes", wcnt, 2);
    chk("R11", "no indirect reads", rcnt, 23);
  endtask

  task automatic t_halt();
    start_prog();
    put(8'h10, 8'h01, 8'h00);
    run(60);
    chk("R10", "reads before halt", rcnt, 3);
    chk("R10", "no writes", wcnt, 0);
    chk("R10", "rd_n idle", rd_n, 1);
    chk("R13", "address bus released", addr_oe_n, 1);
    chk("R2", "operand read address", rlog[2], 8'h11);
  endtask

  task automatic t_wait();
    int snap;
    bit seen;
    start_prog();
    put(8'h10, 8'h50, 8'h66);
    put(8'h12, 8'h51, 8'h80);
    put(8'h14, 8'h51, 8'h81);
    put(8'h16, 8'h01, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wr_n === 1'b0) begin
        wait_n = 1'b0;
        seen = 1'b1;
        break;
      end
    end
    chk("R12", "store cycle seen", seen, 1);
    chk("R13", "data_oe_n on write", data_oe_n, 0);
    @(negedge clk);
    #1;
    snap = rcnt;
    chk("R12", "store completed while waiting", mem[8'h80], 8'h66);
    repeat (20) @(negedge clk);
    #1;
    chk("R12", "no reads while paused", rcnt, snap);
    chk("R12", "next store not done", mem[8'h81], 8'hEE);
    wait_n = 1'b1;
    repeat (40) @(negedge clk);
    #1;
    chk("R12", "resumed store", mem[8'h81], 8'h66);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_arith();
    t_jumps();
    t_shifts();
    t_nops();
    t_halt();
    t_wait();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule